// File: doc/BRIEF.md
# Virtual Maintenance Status Generator

This block sits beside a bank of sixteen virtual interrupt list entries and condenses their state into the maintenance information a hypervisor needs. It reads three things. The first is the state, hardware-link bit and EOI-notify flag of every entry. The second is a control register that it holds itself: a saturating 5-bit EOI counter plus eight enables. The third is the two virtual group enables.

From these it produces the following outputs:
- a bitmap of entries that are free for reuse;
- a bitmap of entries that retired with a pending EOI notification;
- an eight-bit maintenance status word;
- a single maintenance interrupt.

A pulse on the unmatched-EOI input increments the counter. A software write replaces the whole control register. The status word and bitmaps are combinational functions of the inputs and the registered control word. The interrupt output follows any change within the same cycle.

Top module: `vmaint_status_gen`

## Requirements
- R1: Entry state encoding is 2 bits per entry, entry i at `lr_state_i[2i+1:2i]`: 0 invalid, 1 pending, 2 active, 3 pending-and-active. Bit i of `empty_map_o` is 1 exactly when entry i is invalid and either its hardware bit is 1 or its EOI flag is 0.
- R2: Bit i of `eoi_map_o` is 1 exactly when entry i is invalid, its hardware bit is 0 and its EOI flag is 1. Status bit 0 (EOI) is 1 when `eoi_map_o` is nonzero.
- R3: Status bit 1 (underflow) is 1 when control bit 1 is set and fewer than two entries are in a state other than invalid.
- R4: Status bit 3 (no-pending) is 1 when control bit 3 is set and no entry is in state 1 or 3.
- R5: Status bit 2 (entry-not-present) is 1 when control bit 2 is set and the EOI count (control bits [31:27]) is nonzero.
- R6: Status bit 4 is set when control bit 4 is set and the group-0 enable is 1. Status bit 5 is set when control bit 5 is set and the group-0 enable is 0. Status bits 6 and 7 follow the same rule with control bits 6 and 7 and the group-1 enable.
- R7: Each clock cycle with `eoi_miss_i` high and no control write raises the EOI count by one.
- R8: The EOI count saturates at 31; further unmatched EOIs leave it at 31.
- R9: A control write stores `ctl_wdata_i` masked to bits [31:27] and [7:0] (other bits read 0) one cycle later. It takes priority over a simultaneous unmatched EOI. Without write or unmatched EOI the register holds.
- R10: `maint_irq_o` is 1 exactly when control bit 0 (global enable) is set and any status bit is 1.
- R11: After reset the control register reads 0, so the status word and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_state_i | input | 32 | Per-entry 2-bit state |
| lr_hw_i | input | 16 | Per-entry hardware-link bit |
| lr_eoi_i | input | 16 | Per-entry EOI-notify flag |
| vgrp0_en_i | input | 1 | Virtual group 0 enable |
| vgrp1_en_i | input | 1 | Virtual group 1 enable |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 32 | Control register write data |
| eoi_miss_i | input | 1 | Unmatched virtual EOI, one count per cycle high |
| ctl_q_o | output | 32 | Control register contents |
| empty_map_o | output | 16 | Free-entry bitmap |
| eoi_map_o | output | 16 | EOI-maintenance bitmap |
| status_o | output | 8 | Maintenance status word |
| maint_irq_o | output | 1 | Maintenance interrupt |

## Verification
The hardest state to reach is the saturated counter under a simultaneous software write. The counter only moves one step per unmatched EOI, so the boundary lies 31 events away from reset. The bench reaches it in two ways. It writes 30 directly and steps across the boundary. It also holds the unmatched-EOI input high for forty cycles from zero. It then issues a write in the same cycle as another unmatched EOI to show the write wins.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;
  localparam int REG_W    = 32;
  localparam int CTL_EN_W = 8;
  localparam int ST_W     = 8;

  typedef enum logic [1:0] {
    LR_INVALID  = 2'd0,
    LR_PENDING  = 2'd1,
    LR_ACTIVE   = 2'd2,
    LR_PEND_ACT = 2'd3
  } lr_state_e;

  // control enable bit positions
  localparam int CTL_GLOBAL    = 0;
  localparam int CTL_UNDERFLOW = 1;
  localparam int CTL_NOTPRES   = 2;
  localparam int CTL_NOPEND    = 3;
  localparam int CTL_G0_ON     = 4;
  localparam int CTL_G0_OFF    = 5;
  localparam int CTL_G1_ON     = 6;
  localparam int CTL_G1_OFF    = 7;

  // status word, bit 7 down to bit 0
  typedef struct packed {
    logic g1_off;
    logic g1_on;
    logic g0_off;
    logic g0_on;
    logic nopend;
    logic notpres;
    logic underflow;
    logic eoi;
  } status_t;
endpackage

// File: rtl/vmaint_entry_scan.sv
module vmaint_entry_scan
  import vmaint_pkg::*;
#(
  parameter int NUM_LR = 16,
  localparam int CW = $clog2(NUM_LR + 1)
) (
  input  logic [2*NUM_LR-1:0] lr_state,
  input  logic [NUM_LR-1:0]   lr_hw,
  input  logic [NUM_LR-1:0]   lr_eoi,
  output logic [NUM_LR-1:0]   empty_map,
  output logic [NUM_LR-1:0]   eoi_map,
  output logic [CW-1:0]       valid_cnt,
  output logic [CW-1:0]       pend_cnt
);
  logic [NUM_LR-1:0] valid_vec;
  logic [NUM_LR-1:0] pend_vec;

  for (genvar g = 0; g < NUM_LR; g++) begin : g_entry
    lr_state_e st;
    logic      inval;
    assign st           = lr_state_e'(lr_state[2*g +: 2]);
    assign inval        = (st == LR_INVALID);
    assign valid_vec[g] = !inval;
    assign pend_vec[g]  = (st == LR_PENDING) || (st == LR_PEND_ACT);
    assign empty_map[g] = inval && (lr_hw[g] || !lr_eoi[g]);
    assign eoi_map[g]   = inval && !lr_hw[g] && lr_eoi[g];
  end

  always_comb begin
    valid_cnt = '0;
    pend_cnt  = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      valid_cnt = valid_cnt + CW'(valid_vec[i]);
      pend_cnt  = pend_cnt + CW'(pend_vec[i]);
    end
  end
endmodule

// File: rtl/vmaint_ctl_reg.sv
module vmaint_ctl_reg
  import vmaint_pkg::*;
#(
  parameter int EOI_CNT_W = 5,
  localparam int CNT_LSB = REG_W - EOI_CNT_W,
  localparam logic [EOI_CNT_W-1:0] CNT_MAX = {EOI_CNT_W{1'b1}},
  localparam logic [REG_W-1:0] WR_MASK =
    {{EOI_CNT_W{1'b1}}, {(REG_W-EOI_CNT_W-CTL_EN_W){1'b0}}, {CTL_EN_W{1'b1}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             eoi_miss,
  output logic [REG_W-1:0] ctl_q
);
  logic [REG_W-1:0]     ctl_d;
  logic                 ctl_ce;
  logic [EOI_CNT_W-1:0] cnt_q;
  logic                 cnt_sat;

  assign cnt_q   = ctl_q[REG_W-1:CNT_LSB];
  assign cnt_sat = (cnt_q == CNT_MAX);

  // next state: write wins, else saturating increment
  always_comb begin
    ctl_d  = ctl_q;
    ctl_ce = 1'b0;
    if (wr_en) begin
      ctl_d  = wr_data & WR_MASK;
      ctl_ce = 1'b1;
    end else if (eoi_miss && !cnt_sat) begin
      ctl_d[REG_W-1:CNT_LSB] = cnt_q + 1'b1;
      ctl_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_ce) begin
      ctl_q <= ctl_d;
    end
  end

  assert_incr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && eoi_miss && !cnt_sat) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cnt_sat) |=> cnt_sat);

  assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q == ($past(wr_data) & WR_MASK)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !eoi_miss) |=> $stable(ctl_q));
endmodule

// File: rtl/vmaint_status.sv
module vmaint_status
  import vmaint_pkg::*;
#(
  parameter int NUM_LR = 16,
  parameter int EOI_CNT_W = 5,
  localparam int CW = $clog2(NUM_LR + 1)
) (
  input  logic [CTL_EN_W-1:0]  ctl_en,
  input  logic [EOI_CNT_W-1:0] eoi_cnt,
  input  logic [NUM_LR-1:0]    eoi_map,
  input  logic [CW-1:0]        valid_cnt,
  input  logic [CW-1:0]        pend_cnt,
  input  logic                 vgrp0_en,
  input  logic                 vgrp1_en,
  output status_t              status,
  output logic                 irq
);
  always_comb begin
    status.eoi       = |eoi_map;
    status.underflow = ctl_en[CTL_UNDERFLOW] && (valid_cnt < CW'(2));
    status.notpres   = ctl_en[CTL_NOTPRES] && (eoi_cnt != '0);
    status.nopend    = ctl_en[CTL_NOPEND] && (pend_cnt == '0);
    status.g0_on     = ctl_en[CTL_G0_ON] && vgrp0_en;
    status.g0_off    = ctl_en[CTL_G0_OFF] && !vgrp0_en;
    status.g1_on     = ctl_en[CTL_G1_ON] && vgrp1_en;
    status.g1_off    = ctl_en[CTL_G1_OFF] && !vgrp1_en;
    irq              = ctl_en[CTL_GLOBAL] && (|status);
  end
endmodule

// File: rtl/vmaint_status_gen.sv
module vmaint_status_gen
  import vmaint_pkg::*;
#(
  parameter int NUM_LR = 16,
  parameter int EOI_CNT_W = 5,
  localparam int CW = $clog2(NUM_LR + 1),
  localparam int CNT_LSB = REG_W - EOI_CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NUM_LR-1:0] lr_state_i,
  input  logic [NUM_LR-1:0]   lr_hw_i,
  input  logic [NUM_LR-1:0]   lr_eoi_i,
  input  logic                vgrp0_en_i,
  input  logic                vgrp1_en_i,
  input  logic                ctl_wr_i,
  input  logic [REG_W-1:0]    ctl_wdata_i,
  input  logic                eoi_miss_i,
  output logic [REG_W-1:0]    ctl_q_o,
  output logic [NUM_LR-1:0]   empty_map_o,
  output logic [NUM_LR-1:0]   eoi_map_o,
  output logic [ST_W-1:0]     status_o,
  output logic                maint_irq_o
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [CW-1:0] valid_cnt;
  logic [CW-1:0] pend_cnt;
  status_t       status;

  vmaint_entry_scan #(.NUM_LR(NUM_LR)) u_scan (
    .lr_state  (lr_state_i),
    .lr_hw     (lr_hw_i),
    .lr_eoi    (lr_eoi_i),
    .empty_map (empty_map_o),
    .eoi_map   (eoi_map_o),
    .valid_cnt (valid_cnt),
    .pend_cnt  (pend_cnt)
  );

  vmaint_ctl_reg #(.EOI_CNT_W(EOI_CNT_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (ctl_wr_i),
    .wr_data  (ctl_wdata_i),
    .eoi_miss (eoi_miss_i),
    .ctl_q    (ctl_q_o)
  );

  vmaint_status #(.NUM_LR(NUM_LR), .EOI_CNT_W(EOI_CNT_W)) u_status (
    .ctl_en    (ctl_q_o[CTL_EN_W-1:0]),
    .eoi_cnt   (ctl_q_o[REG_W-1:CNT_LSB]),
    .eoi_map   (eoi_map_o),
    .valid_cnt (valid_cnt),
    .pend_cnt  (pend_cnt),
    .vgrp0_en  (vgrp0_en_i),
    .vgrp1_en  (vgrp1_en_i),
    .status    (status),
    .irq       (maint_irq_o)
  );

  assign status_o = status;

  assert_maps_disjoint_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (empty_map_o & eoi_map_o) == '0);

  assert_eoi_raises_irq_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((eoi_map_o != '0) && ctl_q_o[CTL_GLOBAL]) |-> maint_irq_o);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    maint_irq_o |-> (ctl_q_o[CTL_GLOBAL] && (status_o != '0)));

  assert_reset_clear_R11: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (ctl_q_o == '0));
endmodule

// File: tb/vmaint_status_gen_test.sv
module vmaint_status_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed {
    logic [31:0] st;
    logic [15:0] hw;
    logic [15:0] eoi;
    logic [31:0] ctl;
    logic        vg0;
    logic        vg1;
    logic [15:0] emp;
    logic [15:0] eom;
    logic [7:0]  stat;
    logic        irq;
  } vec_t;

  // state, hw, eoi, ctl write, vg0, vg1, expected empty, eoi map, status, irq
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 16'h0000, 16'h0000, 32'h0000_00FF, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 8'hAA, 1'b1},
    '{32'h0000_0000, 16'h0000, 16'hFFFF, 32'h0000_0001, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 8'h01, 1'b1},
    '{32'h0000_0005, 16'h0000, 16'h0000, 32'h0000_00FE, 1'b1, 1'b0, 16'hFFFC, 16'h0000, 8'h90, 1'b0},
    '{32'h0000_0002, 16'h00F0, 16'h00FF, 32'h0800_0005, 1'b0, 1'b1, 16'hFFF0, 16'h000E, 8'h05, 1'b1},
    '{32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF, 32'h0000_000B, 1'b0, 1'b0, 16'h0000, 16'h0000, 8'h00, 1'b0},
    '{32'h4000_0000, 16'h0000, 16'h0000, 32'h0000_000B, 1'b0, 1'b0, 16'h7FFF, 16'h0000, 8'h02, 1'b1},
    '{32'hA000_0000, 16'h0000, 16'h0000, 32'h0000_000B, 1'b0, 1'b0, 16'h3FFF, 16'h0000, 8'h08, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lr_state;
  logic [15:0] lr_hw, lr_eoi;
  logic        vg0, vg1, ctl_wr, eoi_miss;
  logic [31:0] ctl_wdata;
  logic [31:0] ctl_q;
  logic [15:0] empty_map, eoi_map;
  logic [7:0]  status;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmaint_status_gen uut (
    .clk(clk), .rst_n(rst_n), .lr_state_i(lr_state), .lr_hw_i(lr_hw),
    .lr_eoi_i(lr_eoi), .vgrp0_en_i(vg0), .vgrp1_en_i(vg1),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .eoi_miss_i(eoi_miss),
    .ctl_q_o(ctl_q), .empty_map_o(empty_map), .eoi_map_o(eoi_map),
    .status_o(status), .maint_irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [31:0] v, input logic miss);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v; eoi_miss = miss;
    @(negedge clk);
    ctl_wr = 1'b0; eoi_miss = 1'b0;
  endtask

  task automatic miss_cycles(input int n);
    @(negedge clk);
    eoi_miss = 1'b1;
    repeat (n) @(negedge clk);
    eoi_miss = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; lr_state = '0; lr_hw = '0; lr_eoi = '0;
    vg0 = 1'b0; vg1 = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; eoi_miss = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 ctl in reset", ctl_q, 32'h0);
    chk("R11 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 ctl after reset", ctl_q, 32'h0);
    chk("R11 status after reset", {24'b0, status}, 32'h0);
    chk("R1 empty after reset", {16'b0, empty_map}, 32'h0000_FFFF);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      lr_state = VECS[v].st; lr_hw = VECS[v].hw; lr_eoi = VECS[v].eoi;
      vg0 = VECS[v].vg0; vg1 = VECS[v].vg1;
      ctl_wr = 1'b1; ctl_wdata = VECS[v].ctl;
      @(negedge clk);
      ctl_wr = 1'b0;
      chk($sformatf("R1 empty vec %0d", v), {16'b0, empty_map}, {16'b0, VECS[v].emp});
      chk($sformatf("R2 eoi map vec %0d", v), {16'b0, eoi_map}, {16'b0, VECS[v].eom});
      chk($sformatf("R2 eoi bit vec %0d", v), {31'b0, status[0]}, {31'b0, VECS[v].stat[0]});
      chk($sformatf("R3 underflow vec %0d", v), {31'b0, status[1]}, {31'b0, VECS[v].stat[1]});
      chk($sformatf("R5 notpres vec %0d", v), {31'b0, status[2]}, {31'b0, VECS[v].stat[2]});
      chk($sformatf("R4 nopend vec %0d", v), {31'b0, status[3]}, {31'b0, VECS[v].stat[3]});
      chk($sformatf("R6 groups vec %0d", v), {28'b0, status[7:4]}, {28'b0, VECS[v].stat[7:4]});
      chk($sformatf("R10 irq vec %0d", v), {31'b0, irq}, {31'b0, VECS[v].irq});
    end

    // quiet entries: all invalid, no EOI flags, groups off
    @(negedge clk);
    lr_state = '0; lr_hw = '0; lr_eoi = '0; vg0 = 1'b0; vg1 = 1'b0;

    write_ctl(32'hFFFF_FFFF, 1'b0);
    chk("R9 write mask", ctl_q, 32'hF800_00FF);

    write_ctl(32'h0000_0005, 1'b0);
    chk("R5 count zero no status", {24'b0, status}, 32'h0);
    chk("R10 irq off with no status", {31'b0, irq}, 32'h0);
    miss_cycles(1);
    chk("R7 single increment", ctl_q, 32'h0800_0005);
    chk("R5 notpres after miss", {24'b0, status}, 32'h04);
    chk("R10 irq from notpres", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 hold without events", ctl_q, 32'h0800_0005);
    miss_cycles(3);
    chk("R7 three increments", ctl_q, 32'h2000_0005);

    write_ctl(32'hF000_0000, 1'b0);
    miss_cycles(1);
    chk("R8 reach max", ctl_q, 32'hF800_0000);
    miss_cycles(3);
    chk("R8 stays at max", ctl_q, 32'hF800_0000);

    write_ctl(32'h0000_0000, 1'b0);
    miss_cycles(40);
    chk("R8 saturate from zero", ctl_q, 32'hF800_0000);

    write_ctl(32'h1000_0000, 1'b1);
    chk("R9 write beats miss", ctl_q, 32'h1000_0000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule